// File: doc/BRIEF.md
# Framebuffer scan address generator

This block is the pixel-fetch half of a fixed-resolution display controller. Software writes two 32-bit registers over a simple write-only register port. One register holds the frame base address and the other holds a control word. For every visible pixel the block produces the byte address of the memory word that holds that pixel. When the memory returns the word one cycle later, the block unpacks it into 8-bit red, green and blue values. If the display is switched off, it outputs black instead.

Each pixel occupies one 32-bit word, and memory rows are laid out with a pitch wider than the visible line. Only the top 11 bits of the base register take part in address generation, so the frame always starts on a 2 MiB boundary. A rotation bit reverses the scan so that the picture is shown turned through 180 degrees. Register writes are staged in shadow copies and take effect only at the next frame-start pulse. Pixel timing comes from a pixel-enable strobe supplied by an external timing generator.

Top module: `fbscan_top`

## Requirements
- R1: After reset both registers read as zero internally, no fetch is issued until the first frame-start pulse, and the colour outputs and `rgbValid` are 0. A frame started with the reset configuration scans but outputs black.
- R2: A write with `regSel`=0 loads the base register and a write with `regSel`=1 loads the control register. Control bit 0 is display enable and control bit 1 is 180-degree rotation. A control write leaves the base unchanged.
- R3: Only base bits 31:21 are kept. The effective base has bits 20:0 forced to zero.
- R4: In normal order the fetch address for pixel (x,y) is base + 4*(y*ROW_PITCH + x). x advances by one on each qualified `pixEn` and wraps to 0 after H_VIS-1, at which point y advances.
- R5: With rotation set, x is replaced by H_VIS-1-x and y by V_VIS-1-y, so the scan runs from the last pixel of the last row back to the first pixel of the first row.
- R6: Register writes go to shadow copies, and the scan uses active copies that are loaded only on `frameStart`. A write in the same cycle as `frameStart` takes effect only at the following frame.
- R7: `frameStart` restarts the scan at (0,0) even in the middle of a frame. No fetch is issued in the `frameStart` cycle.
- R8: After the last visible pixel of a frame, `fetchValid` stays 0 until the next `frameStart`.
- R9: Memory data `pixWord` is sampled one cycle after the fetch. Two cycles after the fetch, `rgbValid` is 1 and red, green and blue are bits 23:16, 15:8 and 7:0 of that word. Bits 31:24 are ignored.
- R10: When the frame's active enable bit is 0, `rgbValid` still pulses for each pixel but red, green and blue are 0. When `rgbValid` is 0, the colour outputs are 0.
- R11: While `pixEn` is low, the scan position holds and `fetchValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rstN | input | 1 | active-low asynchronous reset |
| regWrEn | input | 1 | register write strobe |
| regSel | input | 1 | 0 selects base, 1 selects control |
| regWrData | input | 32 | register write data |
| frameStart | input | 1 | restarts the scan and loads the active configuration |
| pixEn | input | 1 | advance one pixel this cycle |
| fetchValid | output | 1 | fetch address is valid this cycle |
| fetchAddr | output | 32 | byte address of the pixel word |
| pixWord | input | 32 | word returned by memory one cycle after the fetch |
| rgbValid | output | 1 | colour outputs carry a pixel |
| red | output | 8 | red level |
| green | output | 8 | green level |
| blue | output | 8 | blue level |

## Verification
The bench sweeps every pixel of a reduced 8x4 frame with a 16-word pitch. The sweeps cover normal order, rotated order and a gappy pixel-enable pattern, so a design that confuses the pitch with the visible width, or that mirrors only one axis, produces wrong addresses at row ends. It writes registers mid-frame and in the same cycle as the frame-start pulse. A design that applies writes immediately shows the new base or rotation within the current frame. It also restarts the scan mid-frame and keeps strobing past the last pixel. A restart that does not clear both counters, or a scan that does not stop at the end of the frame, shows up as stray or misaddressed fetches. Memory words carry noise in the top byte and the bench checks that enable gates the colours, which catches a wrong byte lane, an off-by-one latency, or colour output while the display is disabled.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  // strobes and mode bits handed from control to datapath each cycle
  typedef struct packed {
    logic fetch;    // a pixel address is issued this cycle
    logic rotate;   // active frame scans in reversed order
    logic enable;   // active frame shows colour
  } scanCmd_t;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_ROT_BIT = 1;

endpackage

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
  import fbscan_pkg::*;
#(
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int ADDR_W    = 32,
  parameter int BASE_KEEP = 11,
  localparam int XW = $clog2(H_VIS),
  localparam int YW = $clog2(V_VIS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regSel,
  input  logic [ADDR_W-1:0]    regWrData,
  input  logic                 frameStart,
  input  logic                 pixEn,
  output logic [BASE_KEEP-1:0] baseHi,
  output logic [XW-1:0]        xPos,
  output logic [YW-1:0]        yPos,
  output scanCmd_t             cmd
);

  localparam int LOW_W = ADDR_W - BASE_KEEP;
  localparam logic [XW-1:0] X_LAST = XW'(H_VIS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_VIS - 1);

  logic [BASE_KEEP-1:0] shBase, actBase;
  logic [1:0]           shCtl, actCtl;
  logic                 running;
  logic                 step;
  logic                 unusedWrBits;

  assign unusedWrBits = ^regWrData[LOW_W-1:2];

  // shadow registers: written by software at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shBase <= '0;
      shCtl  <= '0;
    end else if (regWrEn) begin
      if (regSel) shCtl  <= regWrData[1:0];
      else        shBase <= regWrData[ADDR_W-1 -: BASE_KEEP];
    end
  end

  // active copies: only loaded at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBase <= '0;
      actCtl  <= '0;
    end else if (frameStart) begin
      actBase <= shBase;
      actCtl  <= shCtl;
    end
  end

  assign step = pixEn && running && !frameStart;

  // raster counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos    <= '0;
      yPos    <= '0;
      running <= 1'b0;
    end else if (frameStart) begin
      xPos    <= '0;
      yPos    <= '0;
      running <= 1'b1;
    end else if (step) begin
      if (xPos == X_LAST) begin
        xPos <= '0;
        if (yPos == Y_LAST) begin
          yPos    <= '0;
          running <= 1'b0;
        end else begin
          yPos <= yPos + 1'b1;
        end
      end else begin
        xPos <= xPos + 1'b1;
      end
    end
  end

  assign baseHi     = actBase;
  assign cmd.fetch  = step;
  assign cmd.rotate = actCtl[CTL_ROT_BIT];
  assign cmd.enable = actCtl[CTL_EN_BIT];

  // R7
  restart_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (xPos == '0 && yPos == '0 && running));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(actBase) && $stable(actCtl)));

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && xPos == X_LAST && yPos == Y_LAST) |=> !running);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pixEn && !frameStart) |=> ($stable(xPos) && $stable(yPos)));

  // R4
  x_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xPos <= X_LAST) && (yPos <= Y_LAST));

endmodule

// File: rtl/fbscan_dp.sv
module fbscan_dp
  import fbscan_pkg::*;
#(
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int ROW_PITCH = 1024,
  parameter int ADDR_W    = 32,
  parameter int BASE_KEEP = 11,
  localparam int XW = $clog2(H_VIS),
  localparam int YW = $clog2(V_VIS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanCmd_t             cmd,
  input  logic [BASE_KEEP-1:0] baseHi,
  input  logic [XW-1:0]        xPos,
  input  logic [YW-1:0]        yPos,
  input  logic [ADDR_W-1:0]    pixWord,
  output logic                 fetchValid,
  output logic [ADDR_W-1:0]    fetchAddr,
  output logic                 rgbValid,
  output logic [7:0]           red,
  output logic [7:0]           green,
  output logic [7:0]           blue
);

  localparam int LOW_W = ADDR_W - BASE_KEEP;
  localparam logic [XW-1:0] X_LAST = XW'(H_VIS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_VIS - 1);

  logic [XW-1:0]     xEff;
  logic [YW-1:0]     yEff;
  logic [ADDR_W-1:0] wordIdx;
  logic [ADDR_W-1:0] baseAddr;
  logic              vld1, en1;
  logic              unusedTop;

  // mirror both axes for a half-turn scan
  assign xEff = cmd.rotate ? (X_LAST - xPos) : xPos;
  assign yEff = cmd.rotate ? (Y_LAST - yPos) : yPos;

  assign wordIdx   = ADDR_W'(yEff) * ADDR_W'(ROW_PITCH) + ADDR_W'(xEff);
  assign baseAddr  = {baseHi, {LOW_W{1'b0}}};
  assign fetchAddr = baseAddr + (wordIdx << 2);
  assign fetchValid = cmd.fetch;

  assign unusedTop = ^pixWord[ADDR_W-1:24];

  // stage 1: remember that a fetch went out and with which enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0;
      en1  <= 1'b0;
    end else begin
      vld1 <= cmd.fetch;
      en1  <= cmd.enable;
    end
  end

  // stage 2: unpack returned word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rgbValid <= 1'b0;
      red      <= '0;
      green    <= '0;
      blue     <= '0;
    end else begin
      rgbValid <= vld1;
      if (vld1 && en1) begin
        red   <= pixWord[23:16];
        green <= pixWord[15:8];
        blue  <= pixWord[7:0];
      end else begin
        red   <= '0;
        green <= '0;
        blue  <= '0;
      end
    end
  end

  // R9
  pixel_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rgbValid |-> $past(cmd.fetch, 2));

  // R10
  black_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rgbValid |-> (red == '0 && green == '0 && blue == '0));

  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (fetchAddr[1:0] == 2'b00));

  // R3
  base_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (fetchAddr[ADDR_W-1 -: BASE_KEEP] >= baseHi));

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int ROW_PITCH = 1024,
  parameter int ADDR_W    = 32,
  parameter int BASE_KEEP = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              frameStart,
  input  logic              pixEn,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] pixWord,
  output logic              rgbValid,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);

  localparam int XW = $clog2(H_VIS);
  localparam int YW = $clog2(V_VIS);

  scanCmd_t             cmd;
  logic [BASE_KEEP-1:0] baseHi;
  logic [XW-1:0]        xPos;
  logic [YW-1:0]        yPos;

  fbscan_ctrl #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .ADDR_W(ADDR_W), .BASE_KEEP(BASE_KEEP)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .frameStart(frameStart), .pixEn(pixEn),
    .baseHi(baseHi), .xPos(xPos), .yPos(yPos), .cmd(cmd)
  );

  fbscan_dp #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .ROW_PITCH(ROW_PITCH),
    .ADDR_W(ADDR_W), .BASE_KEEP(BASE_KEEP)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .baseHi(baseHi),
    .xPos(xPos), .yPos(yPos), .pixWord(pixWord),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .rgbValid(rgbValid), .red(red), .green(green), .blue(blue)
  );

  // R11
  no_fetch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |-> !fetchValid);

  // R7
  no_fetch_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !fetchValid);

endmodule

// File: tb/sim_fbscan_top.sv
module sim_fbscan_top;

  localparam int H = 8;
  localparam int V = 4;
  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic        frameStart = 1'b0, pixEn = 1'b0;
  logic        fetchValid;
  logic [31:0] fetchAddr;
  logic [31:0] pixWord = '0;
  logic        rgbValid;
  logic [7:0]  red, green, blue;

  int total = 0;
  int bad = 0;
  string ph = "R1";

  // bench model
  logic [31:0] shBase = '0, mBase = '0;
  logic [1:0]  shCtl = '0, mCtl = '0;
  int          mx = 0, my = 0;
  bit          mRun = 0;
  bit          e1v = 0, e2v = 0, e1en = 0, e2en = 0;
  logic [31:0] e1a = '0, e2a = '0;

  always #10 clk = ~clk;

  fbscan_top #(.H_VIS(H), .V_VIS(V), .ROW_PITCH(P)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .frameStart(frameStart), .pixEn(pixEn),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .pixWord(pixWord),
    .rgbValid(rgbValid), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[9:2] ^ 8'h11, a[17:10] + 8'h29, a[7:0] ^ a[15:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic step(input bit fs, input bit pe, input bit we,
                      input bit sel, input logic [31:0] d);
    bit expV;
    logic [31:0] expA, expRgb, w;
    int xe, ye;
    @(negedge clk);
    frameStart = fs; pixEn = pe; regWrEn = we; regSel = sel; regWrData = d;
    pixWord = e1v ? memFn(e1a) : 32'hDEAD_BEEF;
    #1;
    expV = pe && mRun && !fs;
    expA = '0;
    chk(fetchValid == expV, ph, "fetchValid", 32'(fetchValid), 32'(expV));
    if (expV) begin
      xe = mCtl[1] ? (H - 1 - mx) : mx;
      ye = mCtl[1] ? (V - 1 - my) : my;
      expA = {mBase[31:21], 21'b0} + 32'(4 * (ye * P + xe));
      chk(fetchAddr == expA, ph, "fetchAddr", fetchAddr, expA);
    end
    chk(rgbValid == e2v, "R9", "rgbValid", 32'(rgbValid), 32'(e2v));
    w = memFn(e2a);
    expRgb = (e2v && e2en) ? {8'h00, w[23:0]} : 32'h0;
    chk({8'h00, red, green, blue} == expRgb, (e2v && e2en) ? "R9" : "R10",
        "rgb", {8'h00, red, green, blue}, expRgb);
    e2v = e1v; e2a = e1a; e2en = e1en;
    e1v = expV; e1a = expA; e1en = mCtl[0];
    if (fs) begin
      mBase = shBase; mCtl = shCtl; mx = 0; my = 0; mRun = 1;
    end else if (pe && mRun) begin
      if (mx == H - 1) begin
        mx = 0;
        if (my == V - 1) begin my = 0; mRun = 0; end
        else my++;
      end else mx++;
    end
    if (we) begin
      if (sel) shCtl = d[1:0];
      else     shBase = d;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=%h exp=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(rgbValid == 1'b0, "R1", "reset rgbValid", 32'(rgbValid), 32'h0);
    chk({red, green, blue} == 24'h0, "R1", "reset rgb", 32'({red, green, blue}), 32'h0);
    chk(fetchValid == 1'b0, "R1", "reset fetch", 32'(fetchValid), 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    ph = "R1";
    run(3);                          // no fetch before frame start
    step(1, 0, 0, 0, 0);
    run(6);                          // reset config: base 0, display off

    ph = "R3";
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    step(0, 0, 1, 1, 32'h0000_0001);
    step(1, 0, 0, 0, 0);
    run(4);

    ph = "R4";
    step(0, 0, 1, 0, 32'h1234_5678);
    step(1, 0, 0, 0, 0);
    run(H * V);

    ph = "R8";
    run(6);

    ph = "R11";
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 60; i++) step(0, (i % 3) != 0, 0, 0, 0);

    ph = "R2";
    step(0, 0, 1, 1, 32'h0000_0003);
    step(1, 0, 0, 0, 0);
    run(5);
    ph = "R5";
    run(H * V - 5 + 3);

    ph = "R6";
    step(1, 0, 0, 0, 0);
    run(5);
    step(0, 1, 1, 0, 32'h0AC0_0000);
    step(0, 1, 1, 1, 32'h0000_0001);
    run(10);
    step(1, 0, 1, 1, 32'h0000_0000);  // write lands with frame start
    run(H * V);

    ph = "R10";
    step(1, 0, 0, 0, 0);
    run(H * V + 2);

    ph = "R7";
    step(0, 0, 1, 1, 32'h0000_0003);
    step(1, 0, 0, 0, 0);
    run(13);
    step(1, 1, 0, 0, 0);              // restart mid-frame with pixEn high
    run(H * V + 2);

    summary();
    $finish;
  end

endmodule